// File: doc/BRIEF.md
# AC'97 Codec Register Bridge

This block sits between a host register bus and an AC'97 codec link controller. Software reaches codec registers through two 32-bit words. The command word holds the codec register index, a direction flag, 16 bits of write data and a few link control bits. The status word returns read data, an echo of the register index it belongs to, codec ready flags and a "fresh data" flag. The bridge passes each accepted command to the link side as one request on a valid/ready port. Read responses come back on a separate response port, and the bridge matches them against the index it sent.

A host write to the command word starts a transaction. The pending flag in the command word stays set until the request has been handed over. Software polls that flag to learn when the command has gone out, and for reads it then polls the fresh-data flag in the status word. The same command word also requests a warm reset of the link. The bridge then holds a reset strobe for a fixed number of cycles. It clears the pending flag, and it starts no further codec request until the primary codec reports ready again.

Top module: `cdc_regbridge`

## Requirements
- R1: After reset the command word reads 0, the status word shows only the two ready inputs (bit 23 primary, bit 22 secondary), and cmd_valid and warm_rst are low.
- R2: An accepted write to the command word (host_sel=1) latches bit 31 as read (1) or write (0), bits 30:24 as the codec register index and bits 15:0 as write data. It sets the pending flag (bit 16 on readback), and it produces exactly one codec request carrying those fields.
- R3: The pending flag clears on the clock edge where the request handshake (cmd_valid and cmd_ready both high) completes. A write command posts nothing to the status word.
- R4: For a read, a response whose index equals the requested index stores the data in status bits 15:0 and the index in bits 30:24, and sets bit 17 (fresh). A response with any other index is ignored.
- R5: A host read of the status word (host_sel=0, host_rd=1) clears bits 17 and 16. If a matching response is posted in the same cycle, the posted data and a set bit 17 remain.
- R6: Accepting a new command clears status bit 17.
- R7: A command-word write while the pending flag is set is ignored: the latched command is unchanged, and the sticky overflow flag, status bit 16, is set.
- R8: Command bit 17 requests a warm reset. warm_rst is then high for WARM_CYC cycles and no codec request is made. The pending flag clears when warm_rst falls. Later commands are accepted but held until pri_ready is high.
- R9: Status bits 23 and 22 follow pri_ready and sec_ready.
- R10: Command bits 21, 20 and 18 drive pd_pri, pd_sec and link_shutdown. The outputs keep those values until the next accepted command.
- R11: If no matching response arrives within RSP_WAIT cycles of a read handshake, the bridge gives up and services the next pending command.
- R12: While cmd_valid is high and cmd_ready is low, cmd_valid stays high and the request fields stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Word select: 0 status, 1 command |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (side effect on the status word only) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the selected word |
| cmd_valid | output | 1 | Codec request valid |
| cmd_ready | input | 1 | Codec request accepted |
| cmd_rd | output | 1 | Request is a read |
| cmd_idx | output | 7 | Codec register index |
| cmd_wdata | output | 16 | Write data |
| rsp_valid | input | 1 | Read response valid |
| rsp_idx | input | 7 | Index of the response |
| rsp_data | input | 16 | Response data |
| pri_ready | input | 1 | Primary codec ready |
| sec_ready | input | 1 | Secondary codec ready |
| warm_rst | output | 1 | Warm reset strobe toward the link |
| link_shutdown | output | 1 | Link shutdown request |
| pd_pri | output | 1 | Primary codec power-down request |
| pd_sec | output | 1 | Secondary codec power-down request |

## Verification
The status word has two functions that can land on the same clock edge: the clear-on-read done by a host status read, and the posting of a matching read response. The bench watches the response port and drives the status read into the exact cycle in which rsp_valid is presented. It then reads the status word back without side effects. The result passes only if the fresh flag is still set and the new data and index are in place. A second case pairs an ignored command write with the overflow flag, and a later status read that clears it.

// File: rtl/cdc_regbridge_pkg.sv
package cdc_regbridge_pkg;

    localparam int HOST_W = 32;
    localparam int IDX_W  = 7;
    localparam int DAT_W  = 16;

    // command word bit positions
    localparam int CTL_RD_BIT = 31;
    localparam int IDX_LSB    = 24;
    localparam int CTL_PDP    = 21;
    localparam int CTL_PDS    = 20;
    localparam int CTL_SHUT   = 18;
    localparam int CTL_WARM   = 17;
    localparam int CTL_NEW    = 16;

    // status word bit positions
    localparam int ST_PRI = 23;
    localparam int ST_SEC = 22;
    localparam int ST_NEW = 17;
    localparam int ST_OVF = 16;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT,
        SQ_WARM,
        SQ_SYNC
    } seq_st_e;

    typedef struct packed {
        logic             rd;
        logic [IDX_W-1:0] idx;
        logic [DAT_W-1:0] data;
        logic             warm;
        logic             shut;
        logic             pdp;
        logic             pds;
    } cmd_t;

endpackage

// File: rtl/cdc_ctrl_reg.sv
module cdc_ctrl_reg
    import cdc_regbridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [HOST_W-1:0] wdata,
    input  logic              done,
    input  logic              stat_rd,
    output logic              accept,
    output cmd_t              cmd,
    output logic              cmd_new,
    output logic              ovf
);

    typedef struct packed {
        cmd_t cmd;
        logic new_f;
        logic ovf;
    } ctrl_s;

    ctrl_s s_d, s_q;
    logic  unused_bits;

    assign unused_bits = ^{wdata[23:22], wdata[19], wdata[CTL_NEW]};

    always_comb begin
        s_d    = s_q;
        accept = wr && !s_q.new_f;
        if (accept) begin
            s_d.cmd.rd   = wdata[CTL_RD_BIT];
            s_d.cmd.idx  = wdata[IDX_LSB +: IDX_W];
            s_d.cmd.data = wdata[DAT_W-1:0];
            s_d.cmd.warm = wdata[CTL_WARM];
            s_d.cmd.shut = wdata[CTL_SHUT];
            s_d.cmd.pdp  = wdata[CTL_PDP];
            s_d.cmd.pds  = wdata[CTL_PDS];
            s_d.new_f    = 1'b1;
        end else if (done) begin
            s_d.new_f = 1'b0;
        end
        if (stat_rd) begin
            s_d.ovf = 1'b0;
        end
        if (wr && s_q.new_f) begin
            s_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd     = s_q.cmd;
    assign cmd_new = s_q.new_f;
    assign ovf     = s_q.ovf;

    // R7
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && cmd_new) |=> (ovf && $stable(cmd)));

endmodule

// File: rtl/cdc_stat_reg.sv
module cdc_stat_reg
    import cdc_regbridge_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             post,
    input  logic [IDX_W-1:0] post_idx,
    input  logic [DAT_W-1:0] post_data,
    input  logic             rd_clr,
    input  logic             acc_clr,
    output logic [IDX_W-1:0] idx,
    output logic [DAT_W-1:0] data,
    output logic             fresh
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [DAT_W-1:0] data;
        logic             fresh;
    } stat_s;

    stat_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rd_clr || acc_clr) begin
            s_d.fresh = 1'b0;
        end
        if (post) begin
            s_d.fresh = 1'b1;
            s_d.idx   = post_idx;
            s_d.data  = post_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign idx   = s_q.idx;
    assign data  = s_q.data;
    assign fresh = s_q.fresh;

    // R5
    post_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        post |=> (fresh && data == $past(post_data)));

endmodule

// File: rtl/cdc_seq.sv
module cdc_seq
    import cdc_regbridge_pkg::*;
#(
    parameter int WARM_CYC = 16,
    parameter int RSP_WAIT = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_new,
    input  logic             cmd_rd,
    input  logic             cmd_warm,
    input  logic [IDX_W-1:0] cmd_idx,
    input  logic             cmd_ready,
    input  logic             rsp_valid,
    input  logic [IDX_W-1:0] rsp_idx,
    input  logic             pri_ready,
    output logic             cmd_valid,
    output logic             issue_done,
    output logic             warm_done,
    output logic             warm_rst,
    output logic             post
);

    localparam int CNT_MAX = (WARM_CYC > RSP_WAIT) ? WARM_CYC : RSP_WAIT;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
    } seq_s;

    seq_s s_d, s_q;

    always_comb begin
        s_d        = s_q;
        issue_done = 1'b0;
        warm_done  = 1'b0;
        post       = 1'b0;
        unique case (s_q.st)
            SQ_IDLE: begin
                s_d.cnt = '0;
                if (cmd_new) begin
                    s_d.st = cmd_warm ? SQ_WARM : SQ_ISSUE;
                end
            end
            SQ_ISSUE: begin
                if (cmd_ready) begin
                    issue_done = 1'b1;
                    s_d.idx    = cmd_idx;
                    s_d.cnt    = '0;
                    s_d.st     = cmd_rd ? SQ_WAIT : SQ_IDLE;
                end
            end
            SQ_WAIT: begin
                if (rsp_valid && rsp_idx == s_q.idx) begin
                    post   = 1'b1;
                    s_d.st = SQ_IDLE;
                end else if (s_q.cnt == CNT_W'(RSP_WAIT - 1)) begin
                    s_d.st = SQ_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            SQ_WARM: begin
                if (s_q.cnt == CNT_W'(WARM_CYC - 1)) begin
                    warm_done = 1'b1;
                    s_d.st    = SQ_SYNC;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            SQ_SYNC: begin
                if (pri_ready) begin
                    s_d.st = SQ_IDLE;
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: SQ_IDLE, cnt: '0, idx: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_valid = (s_q.st == SQ_ISSUE);
    assign warm_rst  = (s_q.st == SQ_WARM);

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> cmd_valid);

endmodule

// File: rtl/cdc_regbridge.sv
module cdc_regbridge
    import cdc_regbridge_pkg::*;
#(
    parameter int WARM_CYC = 16,
    parameter int RSP_WAIT = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_rd,
    output logic [IDX_W-1:0]  cmd_idx,
    output logic [DAT_W-1:0]  cmd_wdata,
    input  logic              rsp_valid,
    input  logic [IDX_W-1:0]  rsp_idx,
    input  logic [DAT_W-1:0]  rsp_data,
    input  logic              pri_ready,
    input  logic              sec_ready,
    output logic              warm_rst,
    output logic              link_shutdown,
    output logic              pd_pri,
    output logic              pd_sec
);

    cmd_t             cmd;
    logic             cmd_new, ovf, accept;
    logic             issue_done, warm_done, post;
    logic             stat_rd, ctl_wr;
    logic [IDX_W-1:0] st_idx;
    logic [DAT_W-1:0] st_data;
    logic             st_fresh;

    assign stat_rd = host_rd && !host_sel;
    assign ctl_wr  = host_wr && host_sel;

    cdc_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (ctl_wr),
        .wdata   (host_wdata),
        .done    (issue_done || warm_done),
        .stat_rd (stat_rd),
        .accept  (accept),
        .cmd     (cmd),
        .cmd_new (cmd_new),
        .ovf     (ovf)
    );

    cdc_seq #(
        .WARM_CYC (WARM_CYC),
        .RSP_WAIT (RSP_WAIT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_new    (cmd_new),
        .cmd_rd     (cmd.rd),
        .cmd_warm   (cmd.warm),
        .cmd_idx    (cmd.idx),
        .cmd_ready  (cmd_ready),
        .rsp_valid  (rsp_valid),
        .rsp_idx    (rsp_idx),
        .pri_ready  (pri_ready),
        .cmd_valid  (cmd_valid),
        .issue_done (issue_done),
        .warm_done  (warm_done),
        .warm_rst   (warm_rst),
        .post       (post)
    );

    cdc_stat_reg u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .post      (post),
        .post_idx  (rsp_idx),
        .post_data (rsp_data),
        .rd_clr    (stat_rd),
        .acc_clr   (accept),
        .idx       (st_idx),
        .data      (st_data),
        .fresh     (st_fresh)
    );

    always_comb begin
        host_rdata = '0;
        if (host_sel) begin
            host_rdata[CTL_RD_BIT]          = cmd.rd;
            host_rdata[IDX_LSB +: IDX_W]    = cmd.idx;
            host_rdata[CTL_PDP]             = cmd.pdp;
            host_rdata[CTL_PDS]             = cmd.pds;
            host_rdata[CTL_SHUT]            = cmd.shut;
            host_rdata[CTL_WARM]            = cmd.warm && cmd_new;
            host_rdata[CTL_NEW]             = cmd_new;
            host_rdata[DAT_W-1:0]           = cmd.data;
        end else begin
            host_rdata[IDX_LSB +: IDX_W]    = st_idx;
            host_rdata[ST_PRI]              = pri_ready;
            host_rdata[ST_SEC]              = sec_ready;
            host_rdata[ST_NEW]              = st_fresh;
            host_rdata[ST_OVF]              = ovf;
            host_rdata[DAT_W-1:0]           = st_data;
        end
    end

    assign cmd_rd        = cmd.rd;
    assign cmd_idx       = cmd.idx;
    assign cmd_wdata     = cmd.data;
    assign link_shutdown = cmd.shut;
    assign pd_pri        = cmd.pdp;
    assign pd_sec        = cmd.pds;

    // R3
    pending_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_new);

    // R12
    req_fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> ($stable(cmd_idx) && $stable(cmd_wdata) && $stable(cmd_rd)));

    // R8
    warm_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst |-> (cmd_new && !cmd_valid));

endmodule

// File: tb/cdc_regbridge_bench.sv
module cdc_regbridge_bench;

    localparam int TB_WARM = 16;
    localparam int TB_WAIT = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        cmd_valid, cmd_rd;
    logic        cmd_ready = 1'b0;
    logic [6:0]  cmd_idx;
    logic [15:0] cmd_wdata;
    logic        rsp_valid = 1'b0;
    logic [6:0]  rsp_idx = '0;
    logic [15:0] rsp_data = '0;
    logic        pri_ready = 1'b1, sec_ready = 1'b0;
    logic        warm_rst, link_shutdown, pd_pri, pd_sec;

    int n_chk = 0, n_err = 0;
    bit done_flag = 0;

    // codec model state
    int          stall = 0, lat = 4, pend = 0, n_req = 0, rdy_cnt = 0;
    logic [6:0]  idx_flip = '0;
    logic [15:0] rsp_val = '0;
    logic        cap_rd = 1'b0;
    logic [6:0]  cap_idx = '0;
    logic [15:0] cap_data = '0;

    always #4 clk = ~clk;

    cdc_regbridge #(.WARM_CYC(TB_WARM), .RSP_WAIT(TB_WAIT)) u_cdc_regbridge (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_rd(cmd_rd),
        .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
        .rsp_idx(rsp_idx), .rsp_data(rsp_data), .pri_ready(pri_ready),
        .sec_ready(sec_ready), .warm_rst(warm_rst),
        .link_shutdown(link_shutdown), .pd_pri(pd_pri), .pd_sec(pd_sec)
    );

    // codec model: acts on the falling edge only
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid) rsp_valid = 1'b0;
            if (pend > 0) begin
                pend = pend - 1;
                if (pend == 0) begin
                    rsp_valid = 1'b1;
                    rsp_idx   = cap_idx ^ idx_flip;
                    rsp_data  = rsp_val;
                end
            end
            if (cmd_ready) begin
                cmd_ready = 1'b0;
            end else if (cmd_valid) begin
                if (stall > 0) begin
                    stall = stall - 1;
                end else begin
                    cmd_ready = 1'b1;
                    n_req     = n_req + 1;
                    cap_rd    = cmd_rd;
                    cap_idx   = cmd_idx;
                    cap_data  = cmd_wdata;
                    if (cmd_rd) pend = lat;
                end
            end
            if (warm_rst) begin
                pri_ready = 1'b0;
                rdy_cnt   = 20;
            end else if (rdy_cnt > 0) begin
                rdy_cnt = rdy_cnt - 1;
                if (rdy_cnt == 0) pri_ready = 1'b1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic host_write(input logic sel, input logic [31:0] d);
        tick(1);
        host_sel = sel; host_wdata = d; host_wr = 1'b1;
        tick(1);
        host_wr = 1'b0;
    endtask

    task automatic status_read(output logic [31:0] v);
        tick(1);
        host_sel = 1'b0; host_rd = 1'b1;
        #1 v = host_rdata;
        tick(1);
        host_rd = 1'b0;
    endtask

    task automatic peek(input logic sel, output logic [31:0] v);
        host_sel = sel;
        #1 v = host_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int k = 0; k < 1000; k++) begin
            peek(1'b1, v);
            if (!v[16]) return;
            tick(1);
        end
    endtask

    task automatic wait_fresh();
        logic [31:0] v;
        for (int k = 0; k < 100; k++) begin
            peek(1'b0, v);
            if (v[17]) return;
            tick(1);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        peek(1'b1, v); check("R1 command word", v, 32'h0);
        peek(1'b0, v); check("R1 status word", v, 32'h0080_0000);
        check("R1 outputs", {cmd_valid, warm_rst, pd_pri, pd_sec, link_shutdown}, 32'h0);
    endtask

    task automatic t_write();
        logic [31:0] v;
        int r0 = n_req;
        host_write(1'b1, 32'h0201_8A5C);
        peek(1'b1, v); check("R2 pending readback", v, 32'h0201_8A5C);
        wait_idle();
        check("R2 one request", n_req - r0, 1);
        check("R2 request fields", {cap_rd, cap_idx, cap_data}, {1'b0, 7'h02, 16'h8A5C});
        peek(1'b1, v); check("R3 pending cleared", v, 32'h0200_8A5C);
        peek(1'b0, v); check("R3 no status posted", v, 32'h0080_0000);
    endtask

    task automatic t_read();
        logic [31:0] v;
        rsp_val = 16'h1234; lat = 4;
        host_write(1'b1, 32'hA601_0000);
        wait_idle();
        wait_fresh();
        peek(1'b0, v); check("R4 read posted", v, 32'h2682_1234);
        status_read(v); check("R4 read value", v, 32'h2682_1234);
        peek(1'b0, v); check("R5 read clears fresh", v, 32'h2680_1234);
        rsp_val = 16'h4321;
        host_write(1'b1, 32'hA601_0000);
        wait_idle();
        wait_fresh();
        peek(1'b0, v); check("R4 second read", v, 32'h2682_4321);
        host_write(1'b1, 32'h0201_0000);
        peek(1'b0, v); check("R6 accept clears fresh", {31'h0, v[17]}, 32'h0);
        wait_idle();
    endtask

    task automatic t_collide();
        logic [31:0] v;
        rsp_val = 16'hBEEF; lat = 5;
        host_write(1'b1, 32'hB001_0000);
        for (int k = 0; k < 100 && !rsp_valid; k++) tick(1);
        host_sel = 1'b0; host_rd = 1'b1;
        tick(1);
        host_rd = 1'b0;
        peek(1'b0, v); check("R5 post wins over clear", v, 32'h3082_BEEF);
    endtask

    task automatic t_stall_ovf();
        logic [31:0] v;
        int r0;
        wait_idle();
        r0 = n_req;
        stall = 6;
        host_write(1'b1, 32'h0A01_1111);
        tick(2);
        check("R12 request held", {cmd_valid, cmd_idx, cmd_wdata}, {1'b1, 7'h0A, 16'h1111});
        check("R12 no handshake yet", n_req - r0, 0);
        host_write(1'b1, 32'h0B01_2222);
        peek(1'b1, v); check("R7 busy write ignored", v, 32'h0A01_1111);
        peek(1'b0, v); check("R7 overflow set", {31'h0, v[16]}, 32'h1);
        status_read(v);
        peek(1'b0, v); check("R5 read clears overflow", {31'h0, v[16]}, 32'h0);
        wait_idle();
        check("R7 original command sent", {cap_idx, cap_data}, {7'h0A, 16'h1111});
        stall = 0;
    endtask

    task automatic t_power();
        logic [31:0] v;
        host_write(1'b1, 32'h1025_0000);
        check("R10 pd_pri/shutdown", {pd_pri, pd_sec, link_shutdown}, 32'h5);
        wait_idle();
        host_write(1'b1, 32'h1011_0000);
        check("R10 pd_sec only", {pd_pri, pd_sec, link_shutdown}, 32'h2);
        wait_idle();
        host_write(1'b1, 32'h1001_0000);
        check("R10 all released", {pd_pri, pd_sec, link_shutdown}, 32'h0);
        wait_idle();
        sec_ready = 1'b1;
        tick(1);
        peek(1'b0, v); check("R9 secondary ready", {30'h0, v[23:22]}, 32'h3);
        sec_ready = 1'b0;
        tick(1);
        peek(1'b0, v); check("R9 secondary not ready", {30'h0, v[23:22]}, 32'h2);
    endtask

    task automatic t_warm();
        logic [31:0] v;
        int r0 = n_req;
        int n = 0;
        host_write(1'b1, 32'h0003_0000);
        peek(1'b1, v); check("R8 warm request readback", v, 32'h0003_0000);
        for (int k = 0; k < 10 && !warm_rst; k++) tick(1);
        while (warm_rst && n < 100) begin
            n++;
            tick(1);
        end
        check("R8 warm pulse length", n, TB_WARM);
        peek(1'b1, v); check("R8 pending cleared after pulse", {31'h0, v[16]}, 32'h0);
        check("R8 no request during warm", n_req - r0, 0);
        host_write(1'b1, 32'h0201_0001);
        tick(4);
        peek(1'b1, v); check("R8 held until ready", {v[16], 31'(n_req - r0)}, 32'h8000_0000);
        wait_idle();
        check("R8 sent after ready", n_req - r0, 1);
    endtask

    task automatic t_timeout();
        logic [31:0] v;
        int r0;
        status_read(v);
        idx_flip = 7'h01; rsp_val = 16'h7777; lat = 3;
        host_write(1'b1, 32'hC001_0000);
        wait_idle();
        tick(10);
        peek(1'b0, v); check("R4 mismatched index ignored", {31'h0, v[17]}, 32'h0);
        r0 = n_req;
        host_write(1'b1, 32'h0201_5555);
        tick(20);
        check("R11 next command waits", n_req - r0, 0);
        for (int k = 0; k < TB_WAIT + 50 && n_req == r0; k++) tick(1);
        check("R11 serviced after give-up", {n_req - r0}, 1);
        check("R11 command data", {16'h0, cap_data}, 32'h5555);
        idx_flip = '0;
        wait_idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_write();
        t_read();
        t_collide();
        t_stall_ovf();
        t_power();
        t_warm();
        t_timeout();
        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule